// File: doc/BRIEF.md
# Byte-Wide Chip-to-Chip Burst Link

This block carries short bursts of 32-bit words between two chips that run from one shared clock. Each direction of the link has ten wires: an 8-bit data lane, an active-low select that frames a transaction, and a drive-enable that marks which cycles carry a real byte. No clock travels with the data. Each chip holds one sending port (host side) and one receiving port (client side) built from the same logic, so the two directions mirror each other.

On the host side, local logic hands over a request made of an 8-bit command code and a word count. It then streams the words on a valid/ready handshake. The port sends the command byte first, then one byte holding the count minus one, then each word as four bytes, low byte first. If the word stream runs dry, the port keeps the select low and drops the drive-enable until the next word arrives. On the client side, the port watches its incoming wires and rebuilds the words. It presents each word with a one-cycle strobe and marks the final one. If the sender releases the select early, the port raises an error pulse.

Top module: `c2c_link`

## Requirements
- R1: After reset, `tx_csn` is 1, `tx_oe` is 0, `req_ready` is 1, `wr_ready` is 0, and `rcv_start`, `rcv_valid`, `rcv_last` and `rcv_ferr` are 0.
- R2: For a request of N words (`req_len_m1` = N-1), the bytes driven while `tx_csn`=0 and `tx_oe`=1 are, in order: the command code, then a byte whose bits [3:0] hold N-1 and bits [7:4] are 0, then 4·N payload bytes, with word k's bits [8j+7:8j] as payload byte 4k+j.
- R3: `tx_oe` is 1 only while `tx_csn` is 0. When the word stream is not ready, `tx_csn` stays 0 and `tx_oe` drops to 0 until a word arrives. With words always available, `tx_csn` is low for exactly 2+4·N cycles.
- R4: `req_ready` is 0 from the cycle after a request is accepted until the last payload byte has been driven. A request raised while `req_ready` is 0 is ignored.
- R5: Between two transactions, `tx_csn` is 1 for at least one cycle.
- R6: When the client receives the first byte of a frame (`rx_csn`=0 and `rx_oe`=1 while idle), it pulses `rcv_start` for one cycle with that byte on `rcv_opcode`.
- R7: The client pulses `rcv_valid` once per received word, with the four bytes placed low byte first in `rcv_data`. `rcv_last` is 1 with the valid of the word whose index equals the received count byte, and 0 with the others.
- R8: If `rx_csn` goes to 1 after the command byte but before all declared payload bytes have arrived, the client pulses `rcv_ferr` for one cycle, does not deliver the partial word, and never raises `rcv_last` for that frame.
- R9: The client ignores any cycle with `rx_oe`=0, even while `rx_csn`=0.
- R10: Extra bytes that arrive after the final word, while `rx_csn` is still 0, are ignored. They produce no word, no start pulse and no error.
- R11: Every burst length from 1 to 16 words is sent and received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both chips |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Host port idle and able to take a request |
| req_opcode | input | 8 | Command code sent as the first byte |
| req_len_m1 | input | 4 | Word count minus one |
| wr_valid | input | 1 | Payload word present |
| wr_ready | output | 1 | Host port takes the payload word this cycle |
| wr_data | input | 32 | Payload word |
| tx_csn | output | 1 | Outgoing frame select, active low |
| tx_oe | output | 1 | Outgoing byte valid / drive enable |
| tx_data | output | 8 | Outgoing byte lane |
| rx_csn | input | 1 | Incoming frame select, active low |
| rx_oe | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte lane |
| rcv_start | output | 1 | One-cycle pulse when a command byte arrives |
| rcv_opcode | output | 8 | Last received command code |
| rcv_valid | output | 1 | One-cycle pulse per rebuilt word |
| rcv_data | output | 32 | Rebuilt word |
| rcv_last | output | 1 | Marks the final word of a burst |
| rcv_ferr | output | 1 | One-cycle pulse on an early-ended frame |

## Verification
A wrong byte index or word counter on the host side appears on the wire at once. The next byte is misplaced, or the select rises one word early or late, which changes the count of select-low cycles within the same burst. On the client side, a stale state register makes the next byte be read as a command code or a count byte. This shows as an extra `rcv_start`, a missing `rcv_last` or a shifted word within a single frame. A lost error path shows as a missing `rcv_ferr` in the cycle after the select rises.

// File: rtl/c2c_pkg.sv
package c2c_pkg;
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 32;
    localparam int MAX_BURST = 16;
    localparam int LEN_W     = $clog2(MAX_BURST);
    localparam int BPW       = WORD_W / BYTE_W;
    localparam int IDX_W     = $clog2(BPW);

    typedef struct packed {
        logic              csn;
        logic              oe;
        logic [BYTE_W-1:0] data;
    } pins_t;

    typedef enum logic [1:0] {TX_IDLE, TX_OPC, TX_LEN, TX_PAY} tx_st_t;
    typedef enum logic [1:0] {RX_IDLE, RX_LEN, RX_PAY, RX_END} rx_st_t;

    function automatic logic [BYTE_W-1:0] len_byte(input logic [LEN_W-1:0] l);
        return BYTE_W'(l);
    endfunction
endpackage

// File: rtl/c2c_host_tx.sv
module c2c_host_tx
    import c2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BYTE_W-1:0] req_opcode,
    input  logic [LEN_W-1:0]  req_len_m1,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [WORD_W-1:0] wr_data,
    output pins_t             link
);
    tx_st_t            st;
    logic [BYTE_W-1:0] op_q;
    logic [LEN_W-1:0]  len_q;
    logic [WORD_W-1:0] sh;
    logic [IDX_W-1:0]  idx;
    logic [LEN_W-1:0]  wcnt;
    logic              have;
    logic              last_byte, last_word;

    assign last_byte = (idx == IDX_W'(BPW-1));
    assign last_word = (wcnt == len_q);
    assign req_ready = (st == TX_IDLE);
    assign wr_ready  = (st == TX_LEN && !have) ||
                       (st == TX_PAY && (!have || (last_byte && !last_word)));

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= TX_IDLE;
            op_q  <= '0;
            len_q <= '0;
            sh    <= '0;
            idx   <= '0;
            wcnt  <= '0;
            have  <= 1'b0;
        end else begin
            case (st)
                TX_IDLE: if (req_valid) begin
                    op_q  <= req_opcode;
                    len_q <= req_len_m1;
                    have  <= 1'b0;
                    idx   <= '0;
                    wcnt  <= '0;
                    st    <= TX_OPC;
                end
                TX_OPC: st <= TX_LEN;
                TX_LEN: begin
                    if (wr_valid) begin
                        sh   <= wr_data;
                        have <= 1'b1;
                        idx  <= '0;
                    end
                    st <= TX_PAY;
                end
                TX_PAY: begin
                    if (have) begin
                        if (last_byte) begin
                            idx <= '0;
                            if (last_word) begin
                                have <= 1'b0;
                                st   <= TX_IDLE;
                            end else begin
                                wcnt <= wcnt + 1'b1;
                                have <= wr_valid;
                                if (wr_valid) sh <= wr_data;
                            end
                        end else begin
                            sh  <= sh >> BYTE_W;
                            idx <= idx + 1'b1;
                        end
                    end else if (wr_valid) begin
                        sh   <= wr_data;
                        have <= 1'b1;
                        idx  <= '0;
                    end
                end
                default: st <= TX_IDLE;
            endcase
        end
    end

    always_comb begin
        link.csn  = (st == TX_IDLE);
        link.oe   = (st == TX_OPC) || (st == TX_LEN) || (st == TX_PAY && have);
        link.data = '0;
        case (st)
            TX_OPC:  link.data = op_q;
            TX_LEN:  link.data = len_byte(len_q);
            TX_PAY:  if (have) link.data = sh[BYTE_W-1:0];
            default: link.data = '0;
        endcase
    end
endmodule

// File: rtl/c2c_client_rx.sv
module c2c_client_rx
    import c2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pins_t             link,
    output logic              rcv_start,
    output logic [BYTE_W-1:0] rcv_opcode,
    output logic              rcv_valid,
    output logic [WORD_W-1:0] rcv_data,
    output logic              rcv_last,
    output logic              rcv_ferr
);
    rx_st_t            st;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  wcnt;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] sh;
    logic              take;

    assign take = !link.csn && link.oe;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= RX_IDLE;
            len_q      <= '0;
            wcnt       <= '0;
            idx        <= '0;
            sh         <= '0;
            rcv_start  <= 1'b0;
            rcv_opcode <= '0;
            rcv_valid  <= 1'b0;
            rcv_data   <= '0;
            rcv_last   <= 1'b0;
            rcv_ferr   <= 1'b0;
        end else begin
            rcv_start <= 1'b0;
            rcv_valid <= 1'b0;
            rcv_last  <= 1'b0;
            rcv_ferr  <= 1'b0;
            case (st)
                RX_IDLE: if (take) begin
                    rcv_opcode <= link.data;
                    rcv_start  <= 1'b1;
                    st         <= RX_LEN;
                end
                RX_LEN: begin
                    if (link.csn) begin
                        rcv_ferr <= 1'b1;
                        st       <= RX_IDLE;
                    end else if (take) begin
                        len_q <= link.data[LEN_W-1:0];
                        wcnt  <= '0;
                        idx   <= '0;
                        st    <= RX_PAY;
                    end
                end
                RX_PAY: begin
                    if (link.csn) begin
                        rcv_ferr <= 1'b1;
                        st       <= RX_IDLE;
                    end else if (take) begin
                        if (idx == IDX_W'(BPW-1)) begin
                            rcv_valid <= 1'b1;
                            rcv_data  <= {link.data, sh[WORD_W-1:BYTE_W]};
                            rcv_last  <= (wcnt == len_q);
                            idx       <= '0;
                            if (wcnt == len_q) st <= RX_END;
                            else wcnt <= wcnt + 1'b1;
                        end else begin
                            sh  <= {link.data, sh[WORD_W-1:BYTE_W]};
                            idx <= idx + 1'b1;
                        end
                    end
                end
                RX_END: if (link.csn) st <= RX_IDLE;
                default: st <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/c2c_link.sv
module c2c_link
    import c2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BYTE_W-1:0] req_opcode,
    input  logic [LEN_W-1:0]  req_len_m1,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [WORD_W-1:0] wr_data,
    output logic              tx_csn,
    output logic              tx_oe,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              rx_csn,
    input  logic              rx_oe,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rcv_start,
    output logic [BYTE_W-1:0] rcv_opcode,
    output logic              rcv_valid,
    output logic [WORD_W-1:0] rcv_data,
    output logic              rcv_last,
    output logic              rcv_ferr
);
    pins_t out_pins, in_pins;

    c2c_host_tx u_host (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_opcode(req_opcode), .req_len_m1(req_len_m1),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .link(out_pins)
    );

    assign tx_csn  = out_pins.csn;
    assign tx_oe   = out_pins.oe;
    assign tx_data = out_pins.data;

    assign in_pins.csn  = rx_csn;
    assign in_pins.oe   = rx_oe;
    assign in_pins.data = rx_data;

    c2c_client_rx u_client (
        .clk(clk), .rst(rst), .link(in_pins),
        .rcv_start(rcv_start), .rcv_opcode(rcv_opcode),
        .rcv_valid(rcv_valid), .rcv_data(rcv_data),
        .rcv_last(rcv_last), .rcv_ferr(rcv_ferr)
    );
endmodule

// File: rtl/c2c_link_chk.sv
module c2c_link_chk
    import c2c_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              tx_csn,
    input logic              tx_oe,
    input logic [BYTE_W-1:0] tx_data,
    input logic              rcv_start,
    input logic              rcv_valid,
    input logic              rcv_last,
    input logic              rcv_ferr
);
    a_r3_oe_inside_frame: assert property (@(posedge clk) disable iff (rst)
        tx_oe |-> !tx_csn);

    a_r4_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        !tx_csn |-> !req_ready);

    a_r5_ready_after_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_csn) |-> req_ready);

    a_r2_count_byte_second: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_csn) |=> (!tx_csn && tx_oe && tx_data[BYTE_W-1:LEN_W] == '0));

    a_r6_start_single: assert property (@(posedge clk) disable iff (rst)
        rcv_start |=> !rcv_start);

    a_r7_last_with_valid: assert property (@(posedge clk) disable iff (rst)
        rcv_last |-> rcv_valid);

    a_r8_err_no_word: assert property (@(posedge clk) disable iff (rst)
        rcv_ferr |-> !rcv_valid);
endmodule

bind c2c_link c2c_link_chk u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .tx_csn(tx_csn), .tx_oe(tx_oe), .tx_data(tx_data),
    .rcv_start(rcv_start), .rcv_valid(rcv_valid),
    .rcv_last(rcv_last), .rcv_ferr(rcv_ferr)
);

// File: tb/c2c_link_tb.sv
`timescale 1ns/1ps
module c2c_link_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_opcode = '0;
    logic [3:0]  req_len_m1 = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [31:0] wr_data = '0;
    logic        tx_csn, tx_oe;
    logic [7:0]  tx_data;
    logic        rx_csn, rx_oe;
    logic [7:0]  rx_data;
    logic        rcv_start, rcv_valid, rcv_last, rcv_ferr;
    logic [7:0]  rcv_opcode;
    logic [31:0] rcv_data;

    logic        inj = 1'b0;
    logic        b_csn = 1'b1, b_oe = 1'b0;
    logic [7:0]  b_data = '0;

    assign rx_csn  = inj ? b_csn  : tx_csn;
    assign rx_oe   = inj ? b_oe   : tx_oe;
    assign rx_data = inj ? b_data : tx_data;

    always #10 clk = ~clk;

    c2c_link u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_opcode(req_opcode), .req_len_m1(req_len_m1),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .tx_csn(tx_csn), .tx_oe(tx_oe), .tx_data(tx_data),
        .rx_csn(rx_csn), .rx_oe(rx_oe), .rx_data(rx_data),
        .rcv_start(rcv_start), .rcv_opcode(rcv_opcode),
        .rcv_valid(rcv_valid), .rcv_data(rcv_data),
        .rcv_last(rcv_last), .rcv_ferr(rcv_ferr)
    );

    int total = 0, bad = 0;
    bit finished = 0;

    // monitor state
    int          cs_cyc, oe_cyc, nb, nw, n_start, n_ferr, n_last;
    logic [7:0]  mbytes [0:127];
    logic [31:0] mwords [0:31];
    logic        mlast  [0:31];
    logic [7:0]  m_op;
    logic [31:0] wbuf   [0:15];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr();
        cs_cyc = 0; oe_cyc = 0; nb = 0; nw = 0;
        n_start = 0; n_ferr = 0; n_last = 0; m_op = '0;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (!tx_csn) cs_cyc++;
            if (!tx_csn && tx_oe) begin
                oe_cyc++;
                if (nb < 128) mbytes[nb] = tx_data;
                nb++;
            end
            if (rcv_start) begin n_start++; m_op = rcv_opcode; end
            if (rcv_valid) begin
                if (nw < 32) begin mwords[nw] = rcv_data; mlast[nw] = rcv_last; end
                nw++;
            end
            if (rcv_last) n_last++;
            if (rcv_ferr) n_ferr++;
        end
    end

    // R2 R3 R4 R6 R7 R11: loopback burst of n words
    task automatic run_burst(input logic [7:0] op, input int n, input bit stall, input bit poke);
        bit busy_low = 0;
        bit bytes_ok = 1;
        bit words_ok = 1;
        clr();
        for (int k = 0; k < n; k++) wbuf[k] = {8'(k) * 8'h11, op, 8'(n), 8'hC3 ^ 8'(k)};
        fork
            begin
                @(negedge clk);
                req_valid = 1'b1; req_opcode = op; req_len_m1 = 4'(n - 1);
                @(negedge clk);
                req_valid = 1'b0;
            end
            begin
                int k = 0;
                int cyc = 0;
                while (k < n) begin
                    bit fire;
                    @(negedge clk);
                    cyc++;
                    if (stall && (cyc % 3 == 0)) wr_valid = 1'b0;
                    else begin wr_valid = 1'b1; wr_data = wbuf[k]; end
                    fire = wr_valid && wr_ready;
                    @(posedge clk);
                    if (fire) k++;
                end
                @(negedge clk);
                wr_valid = 1'b0;
            end
            begin
                if (poke) begin
                    repeat (4) @(negedge clk);
                    req_valid = 1'b1; req_opcode = 8'hEE; req_len_m1 = 4'd3;
                    busy_low = !req_ready;
                    @(negedge clk);
                    req_valid = 1'b0;
                end
            end
        join
        while (!tx_csn) @(negedge clk);
        repeat (3) @(negedge clk);

        if (nb != 2 + 4 * n) bytes_ok = 0;
        else begin
            if (mbytes[0] != op || mbytes[1] != 8'(n - 1)) bytes_ok = 0;
            for (int k = 0; k < n; k++)
                for (int j = 0; j < 4; j++)
                    if (mbytes[2 + 4 * k + j] != wbuf[k][8 * j +: 8]) bytes_ok = 0;
        end
        chk(bytes_ok, "R2 wire byte order", nb, 2 + 4 * n);
        chk(oe_cyc == 2 + 4 * n, "R3 enabled byte cycles", oe_cyc, 2 + 4 * n);
        if (!stall) chk(cs_cyc == 2 + 4 * n, "R3 select-low cycles", cs_cyc, 2 + 4 * n);
        else chk(cs_cyc > 2 + 4 * n, "R3 stall holds select with enable low", cs_cyc, 2 + 4 * n + 1);
        chk(n_start == 1 && m_op == op, "R6 start pulse and code", m_op, op);
        if (nw != n) words_ok = 0;
        else
            for (int k = 0; k < n; k++)
                if (mwords[k] != wbuf[k] || mlast[k] != (k == n - 1)) words_ok = 0;
        chk(words_ok, "R7 R11 rebuilt words and last flag", nw, n);
        chk(n_ferr == 0, "R8 no error on full frame", n_ferr, 0);
        if (poke) begin
            chk(busy_low, "R4 ready low while busy", 0, 1);
            chk(n_start == 1, "R4 busy request ignored", n_start, 1);
        end
        chk(req_ready == 1'b1 && tx_csn == 1'b1, "R5 idle after frame", req_ready, 1);
    endtask

    task automatic inj_byte(input logic [7:0] d, input logic en);
        @(negedge clk);
        b_csn = 1'b0; b_oe = en; b_data = d;
    endtask

    task automatic inj_end();
        @(negedge clk);
        b_csn = 1'b1; b_oe = 1'b0; b_data = '0;
        repeat (3) @(negedge clk);
    endtask

    // R8 R9: early end with a disabled cycle inside
    task automatic run_short_frame();
        clr();
        inj = 1'b1;
        inj_byte(8'h5A, 1);
        inj_byte(8'h02, 1);
        inj_byte(8'h11, 1);
        inj_byte(8'hFF, 0);
        inj_byte(8'h22, 1);
        inj_byte(8'h33, 1);
        inj_byte(8'h44, 1);
        inj_byte(8'h55, 1);
        inj_end();
        chk(nw == 1 && mwords[0] == 32'h44332211, "R9 disabled cycle skipped", mwords[0], 32'h44332211);
        chk(n_ferr == 1, "R8 error pulse on early end", n_ferr, 1);
        chk(n_last == 0, "R8 no last on cut frame", n_last, 0);
        inj = 1'b0;
    endtask

    // R10: overlong frame
    task automatic run_long_frame();
        clr();
        inj = 1'b1;
        inj_byte(8'h77, 1);
        inj_byte(8'h00, 1);
        inj_byte(8'hA1, 1);
        inj_byte(8'hB2, 1);
        inj_byte(8'hC3, 1);
        inj_byte(8'hD4, 1);
        inj_byte(8'h99, 1);
        inj_byte(8'h98, 1);
        inj_end();
        chk(nw == 1 && mwords[0] == 32'hD4C3B2A1 && mlast[0], "R10 one word with last", mwords[0], 32'hD4C3B2A1);
        chk(n_start == 1 && n_ferr == 0, "R10 extra bytes ignored", n_start, 1);
        inj = 1'b0;
    endtask

    task automatic run_reset();
        @(negedge clk);
        chk(tx_csn == 1'b1 && tx_oe == 1'b0, "R1 link idle", {tx_csn, tx_oe}, 2'b10);
        chk(req_ready == 1'b1 && wr_ready == 1'b0, "R1 local handshake", {req_ready, wr_ready}, 2'b10);
        chk({rcv_start, rcv_valid, rcv_last, rcv_ferr} == 4'b0, "R1 client quiet",
            {rcv_start, rcv_valid, rcv_last, rcv_ferr}, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        run_reset();
        run_burst(8'h3C, 1, 0, 0);
        run_burst(8'hA7, 16, 0, 1);
        run_burst(8'h42, 5, 1, 0);
        run_short_frame();
        run_long_frame();
        run_burst(8'h81, 3, 0, 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule